// File: doc/BRIEF.md
# Video-Mode Lane State Sequencer

This block paces the frame of a serial display host running in video mode. It counts lines through four vertical regions in a fixed order: sync, back porch, active picture and front porch. At the start of each line it decides whether the single data lane stays in the low-power stop state (both wires high, no traffic) or asks the PHY for a high-speed burst. During a burst it offers short sync packets, and on picture lines a pixel payload request, to a downstream packet stage. When the burst is over it returns the lane to the stop state.

Each line lasts a fixed number of byte clocks set by a parameter. The line timing does not depend on whether the line used a burst. A configuration input picks one of two blanking styles. In standard style every line carries a burst, including the sync and blanking lines. In strict low-power style the lane stays in the stop state for the whole vertical sync and blanking interval, and bursts happen only on picture lines. The four line counts and the style input are captured only at a frame boundary, so a change made during a frame first applies to the following frame. Low-power escape transfers are never used.

Top module: `dsi_vmode_lane_seq`

## Requirements
- R1: After reset, and for as long as `enable` has never been raised, `hs_req` and `pkt_valid` are both 0.
- R2: Once enabled, lines follow the order sync, back porch, active, front porch, and the order then repeats. Each region lasts its programmed number of lines, where a count of 0 acts as 1. Every line lasts exactly LINE_CLKS clock cycles.
- R3: In standard style, each non-active line has a burst with one short packet. The first sync line carries type 6'h01 (sync start). The first back-porch line carries type 6'h11 (sync end). Every other sync, back-porch and front-porch line carries type 6'h21 (line start).
- R4: In both styles, each active line carries type 6'h21 followed by a pixel payload request of type 6'h3E. No other type value ever appears on `pkt_type` while `pkt_valid` is high.
- R5: In strict style, `hs_req` stays 0 on every sync, back-porch and front-porch line.
- R6: A burst begins with `hs_req` rising one cycle after the line starts. `hs_req` stays high while `phy_ready` is 0. The first `pkt_valid` comes in the cycle after `phy_ready` is sampled high.
- R7: `pkt_valid` is high only while `hs_req` is high. While `pkt_ready` is low, `pkt_valid` stays high and `pkt_type` stays unchanged.
- R8: After the last packet of a line is accepted, `hs_req` stays high until `tx_done` is sampled high, and falls in the next cycle. The lane is back in the stop state before the line ends.
- R9: The four line counts and `strict_lp` are captured when a frame starts. A change made during a frame takes effect at the next frame boundary.
- R10: If `enable` falls, the current line still completes, including its burst. The lane then stays in the stop state with no packets. When `enable` rises again, the sequence restarts at the first sync line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; sampled at line boundaries while running |
| strict_lp | input | 1 | 1 = stop state through all vertical sync and blanking lines |
| vsync_lines | input | CNT_W | Line count of the sync region |
| vbp_lines | input | CNT_W | Line count of the back porch |
| vact_lines | input | CNT_W | Line count of the active region |
| vfp_lines | input | CNT_W | Line count of the front porch |
| phy_ready | input | 1 | PHY is in high-speed mode and can take packets |
| pkt_ready | input | 1 | Packet stage accepts the offered packet |
| tx_done | input | 1 | PHY has finished sending the last packet of the burst |
| hs_req | output | 1 | Lane mode request: 1 = high speed, 0 = stop state |
| pkt_valid | output | 1 | A packet is offered |
| pkt_type | output | 6 | Data type of the offered packet |

## Verification
The properties assume the PHY and the packet stage answer fast enough for each burst, from `hs_req` rising through `tx_done`, to finish inside one line. The strict-style and disabled-state properties rely on this: they expect the lane to be idle at every line boundary. They also assume `tx_done` is raised only after the last packet of a burst has been accepted. The bench's PHY model raises `phy_ready`, releases `pkt_ready` and pulses `tx_done` after delays set per scenario. The longest burst the bench uses spans 11 cycles, which fits well within its 16-cycle line. All four line counts the bench programs are at least 1.

// File: rtl/dsi_seq_pkg.sv
package dsi_seq_pkg;

   localparam int NPH = 4;

   typedef enum logic [1:0] {
      PH_VSYNC = 2'd0,
      PH_VBP   = 2'd1,
      PH_ACT   = 2'd2,
      PH_VFP   = 2'd3
   } vphase_e;

   typedef enum logic [1:0] {
      LN_IDLE  = 2'd0,
      LN_REQ   = 2'd1,
      LN_SEND  = 2'd2,
      LN_DRAIN = 2'd3
   } lane_st_e;

   localparam logic [5:0] DT_VSYNC_START = 6'h01;
   localparam logic [5:0] DT_VSYNC_END   = 6'h11;
   localparam logic [5:0] DT_LINE_START  = 6'h21;
   localparam logic [5:0] DT_PIXELS      = 6'h3E;

   typedef struct packed {
      logic       use_hs;
      logic [5:0] first_dt;
      logic       with_pix;
   } line_plan_t;

   function automatic vphase_e next_phase(vphase_e ph);
      case (ph)
         PH_VSYNC: return PH_VBP;
         PH_VBP:   return PH_ACT;
         PH_ACT:   return PH_VFP;
         default:  return PH_VSYNC;
      endcase
   endfunction

   function automatic line_plan_t plan_line(vphase_e ph, logic first, logic strict);
      line_plan_t p;
      p.use_hs   = 1'b1;
      p.first_dt = DT_LINE_START;
      p.with_pix = 1'b0;
      if (ph == PH_ACT) begin
         p.with_pix = 1'b1;
      end else if (strict) begin
         p.use_hs = 1'b0;
      end else if (first && ph == PH_VSYNC) begin
         p.first_dt = DT_VSYNC_START;
      end else if (first && ph == PH_VBP) begin
         p.first_dt = DT_VSYNC_END;
      end
      return p;
   endfunction

endpackage

// File: rtl/dsi_line_pacer.sv
module dsi_line_pacer #(
   parameter int LINE_CLKS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic line_start_o,
   output logic line_end_o
);

   localparam int CW = (LINE_CLKS > 2) ? $clog2(LINE_CLKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(LINE_CLKS - 1);

   generate
      if (LINE_CLKS < 8) begin : g_bad_len
         $error("dsi_line_pacer: LINE_CLKS must be at least 8");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign line_start_o = run_i && (cnt_q == '0);
   assign line_end_o   = run_i && (cnt_q == LAST);

endmodule

// File: rtl/dsi_frame_tracker.sv
module dsi_frame_tracker
   import dsi_seq_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        enable_i,
   input  logic                        line_end_i,
   input  logic                        strict_i,
   input  logic [NPH-1:0][CNT_W-1:0]   len_i,
   output logic                        run_o,
   output vphase_e                     phase_o,
   output logic                        first_o,
   output logic                        strict_o
);

   logic [CNT_W-1:0] shadow_q [NPH];
   logic             run_q;
   vphase_e          phase_q;
   logic [CNT_W-1:0] idx_q;
   logic             strict_q;

   logic [CNT_W-1:0] cur_len;
   logic             last_line;
   logic             go;
   logic             wrap;
   logic             load;

   always_comb begin
      cur_len   = shadow_q[phase_q];
      last_line = ({1'b0, idx_q} + 1'b1) >= {1'b0, cur_len};
      go        = !run_q && enable_i;
      wrap      = run_q && line_end_i && enable_i && last_line && (phase_q == PH_VFP);
      load      = go || wrap;
   end

   genvar g;
   generate
      for (g = 0; g < NPH; g++) begin : g_shadow
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shadow_q[g] <= '0;
            end else if (load) begin
               shadow_q[g] <= len_i[g];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         phase_q  <= PH_VSYNC;
         idx_q    <= '0;
         strict_q <= 1'b0;
      end else if (go) begin
         run_q    <= 1'b1;
         phase_q  <= PH_VSYNC;
         idx_q    <= '0;
         strict_q <= strict_i;
      end else if (run_q && line_end_i) begin
         if (!enable_i) begin
            run_q   <= 1'b0;
            phase_q <= PH_VSYNC;
            idx_q   <= '0;
         end else if (last_line) begin
            idx_q   <= '0;
            phase_q <= next_phase(phase_q);
            if (phase_q == PH_VFP) begin
               strict_q <= strict_i;
            end
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign run_o    = run_q;
   assign phase_o  = phase_q;
   assign first_o  = (idx_q == '0);
   assign strict_o = strict_q;

endmodule

// File: rtl/dsi_lane_ctrl.sv
module dsi_lane_ctrl
   import dsi_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_start_i,
   input  line_plan_t plan_i,
   input  logic       phy_ready_i,
   input  logic       pkt_ready_i,
   input  logic       tx_done_i,
   output logic       hs_req_o,
   output logic       pkt_valid_o,
   output logic [5:0] pkt_type_o,
   output lane_st_e   state_o
);

   lane_st_e   st_q;
   logic [5:0] dt_q;
   logic       pix_pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= LN_IDLE;
         dt_q       <= '0;
         pix_pend_q <= 1'b0;
      end else begin
         case (st_q)
            LN_IDLE: begin
               if (line_start_i && plan_i.use_hs) begin
                  st_q       <= LN_REQ;
                  dt_q       <= plan_i.first_dt;
                  pix_pend_q <= plan_i.with_pix;
               end
            end
            LN_REQ: begin
               if (phy_ready_i) begin
                  st_q <= LN_SEND;
               end
            end
            LN_SEND: begin
               if (pkt_ready_i) begin
                  if (pix_pend_q) begin
                     dt_q       <= DT_PIXELS;
                     pix_pend_q <= 1'b0;
                  end else begin
                     st_q <= LN_DRAIN;
                  end
               end
            end
            default: begin
               if (tx_done_i) begin
                  st_q <= LN_IDLE;
               end
            end
         endcase
      end
   end

   assign hs_req_o    = (st_q != LN_IDLE);
   assign pkt_valid_o = (st_q == LN_SEND);
   assign pkt_type_o  = dt_q;
   assign state_o     = st_q;

endmodule

// File: rtl/dsi_vmode_lane_seq.sv
module dsi_vmode_lane_seq
   import dsi_seq_pkg::*;
#(
   parameter int LINE_CLKS = 64,
   parameter int CNT_W     = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             strict_lp,
   input  logic [CNT_W-1:0] vsync_lines,
   input  logic [CNT_W-1:0] vbp_lines,
   input  logic [CNT_W-1:0] vact_lines,
   input  logic [CNT_W-1:0] vfp_lines,
   input  logic             phy_ready,
   input  logic             pkt_ready,
   input  logic             tx_done,
   output logic             hs_req,
   output logic             pkt_valid,
   output logic [5:0]       pkt_type
);

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("dsi_vmode_lane_seq: CNT_W must lie in 2..16");
      end
   endgenerate

   logic [NPH-1:0][CNT_W-1:0] lens;
   logic                      run_w;
   vphase_e                   phase_w;
   logic                      first_w;
   logic                      strict_w;
   logic                      line_start;
   logic                      line_end;
   line_plan_t                plan;
   lane_st_e                  lane_st_w;

   assign lens = {vfp_lines, vact_lines, vbp_lines, vsync_lines};

   dsi_line_pacer #(.LINE_CLKS(LINE_CLKS)) u_pacer (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_i        (run_w),
      .line_start_o (line_start),
      .line_end_o   (line_end)
   );

   dsi_frame_tracker #(.CNT_W(CNT_W)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable_i   (enable),
      .line_end_i (line_end),
      .strict_i   (strict_lp),
      .len_i      (lens),
      .run_o      (run_w),
      .phase_o    (phase_w),
      .first_o    (first_w),
      .strict_o   (strict_w)
   );

   always_comb begin
      plan = plan_line(phase_w, first_w, strict_w);
   end

   dsi_lane_ctrl u_lane (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_start_i (line_start),
      .plan_i       (plan),
      .phy_ready_i  (phy_ready),
      .pkt_ready_i  (pkt_ready),
      .tx_done_i    (tx_done),
      .hs_req_o     (hs_req),
      .pkt_valid_o  (pkt_valid),
      .pkt_type_o   (pkt_type),
      .state_o      (lane_st_w)
   );

endmodule

// File: rtl/dsi_vmode_lane_seq_chk.sv
module dsi_vmode_lane_seq_chk
   import dsi_seq_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       hs_req,
   input logic       pkt_valid,
   input logic [5:0] pkt_type,
   input logic       pkt_ready,
   input logic       phy_ready,
   input logic       tx_done,
   input logic       run,
   input vphase_e    phase,
   input logic       strict
);

   // R7: packets are offered only during a high-speed burst
   assert_pkt_in_hs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> hs_req);

   // R7: an unaccepted packet stays offered and unchanged
   assert_pkt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_type)));

   // R6: first packet of a burst only after the PHY reported ready
   assert_ready_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pkt_valid) |-> $past(phy_ready));

   // R8: the lane leaves high speed only after end of transmission
   assert_hs_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_req) |-> $past(tx_done));

   // R5: strict style keeps the stop state outside the active region
   assert_strict_lp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (strict && phase != PH_ACT) |-> !hs_req);

   // R10: no burst while the sequencer is stopped
   assert_idle_lp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!hs_req && !pkt_valid));

   // R4: only the four defined data types are ever offered
   assert_type_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> (pkt_type == DT_VSYNC_START || pkt_type == DT_VSYNC_END ||
                     pkt_type == DT_LINE_START  || pkt_type == DT_PIXELS));

endmodule

bind dsi_vmode_lane_seq dsi_vmode_lane_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hs_req    (hs_req),
   .pkt_valid (pkt_valid),
   .pkt_type  (pkt_type),
   .pkt_ready (pkt_ready),
   .phy_ready (phy_ready),
   .tx_done   (tx_done),
   .run       (run_w),
   .phase     (phase_w),
   .strict    (strict_w)
);

// File: tb/tb_dsi_vmode_lane_seq.sv
module tb_dsi_vmode_lane_seq;

   localparam int CLK_PERIOD = 10;
   localparam int L          = 16;
   localparam int CW         = 6;
   localparam int MAXL       = 64;
   localparam int WD_CYCLES  = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          strict_lp = 1'b0;
   logic [CW-1:0] vsync_lines = '0, vbp_lines = '0, vact_lines = '0, vfp_lines = '0;
   logic          phy_ready = 1'b0, pkt_ready = 1'b0, tx_done = 1'b0;
   logic          hs_req, pkt_valid;
   logic [5:0]    pkt_type;

   dsi_vmode_lane_seq #(.LINE_CLKS(L), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .strict_lp(strict_lp),
      .vsync_lines(vsync_lines), .vbp_lines(vbp_lines),
      .vact_lines(vact_lines), .vfp_lines(vfp_lines),
      .phy_ready(phy_ready), .pkt_ready(pkt_ready), .tx_done(tx_done),
      .hs_req(hs_req), .pkt_valid(pkt_valid), .pkt_type(pkt_type)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_bad = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // scenario configuration: first frame A, later frames B
   int ca[4], cb[4];
   bit sa, sb;
   int cur_d = 1, cur_s = 0, cur_e = 1;
   int base = 0;
   bit mon_on = 1'b0;

   // per-line observations
   int         ln_rise[MAXL], ln_hi[MAXL], ln_n[MAXL], ln_vfirst[MAXL];
   int         ln_vcyc[MAXL], ln_endhs[MAXL];
   logic [5:0] ln_t[MAXL][2];

   // PHY and packet-stage model plus monitor
   int  hs_age = 0, stall = 0, dage = 0;
   bit  sent_any = 0, hs_prev = 0, rdy_n;
   always @(negedge clk) begin
      if (!hs_req) begin
         hs_age = 0; stall = cur_s; sent_any = 0; dage = 0;
      end else begin
         hs_age++;
      end
      phy_ready = hs_req && (hs_age >= cur_d);
      rdy_n = pkt_valid && (stall == 0);
      if (pkt_valid && stall > 0) stall--;
      if (hs_req && sent_any && !pkt_valid) dage++;
      tx_done = hs_req && sent_any && !pkt_valid && (dage >= cur_e);
      if (mon_on && cyc >= base) begin
         int rel, k;
         rel = cyc - base;
         k = rel / L;
         if (k < MAXL) begin
            if (hs_req && !hs_prev) ln_rise[k] = cyc;
            if (hs_req) ln_hi[k]++;
            if (pkt_valid) begin
               ln_vcyc[k]++;
               if (ln_vfirst[k] < 0) ln_vfirst[k] = cyc - ln_rise[k];
            end
            if (pkt_valid && rdy_n) begin
               if (ln_n[k] < 2) ln_t[k][ln_n[k]] = pkt_type;
               ln_n[k]++;
            end
            if (rel % L == L - 1) ln_endhs[k] = hs_req;
         end
      end
      if (pkt_valid && rdy_n) sent_any = 1;
      pkt_ready = rdy_n;
      hs_prev = hs_req;
   end

   task automatic chk(string rq, int act, int exp, string what);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic wait_cyc(int x);
      while (cyc < x) @(negedge clk);
   endtask

   function automatic void exp_line(int k, int tot, output int n,
                                    output int t0, output int t1, output string tag);
      int c[4];
      int idx, ph, i, na, nb;
      bit s;
      na = ca[0] + ca[1] + ca[2] + ca[3];
      nb = cb[0] + cb[1] + cb[2] + cb[3];
      n = 0; t0 = 0; t1 = 0; tag = "R10";
      if (k >= tot) return;
      if (k < na) begin c = ca; s = sa; idx = k; end
      else begin c = cb; s = sb; idx = (k - na) % nb; end
      if (idx < c[0]) begin ph = 0; i = idx; end
      else if (idx < c[0] + c[1]) begin ph = 1; i = idx - c[0]; end
      else if (idx < c[0] + c[1] + c[2]) begin ph = 2; i = 0; end
      else begin ph = 3; i = 0; end
      if (ph == 2) begin
         n = 2; t0 = 'h21; t1 = 'h3E; tag = "R4";
      end else if (s) begin
         n = 0; tag = "R5";
      end else begin
         n = 1; tag = "R3";
         t0 = (ph == 0 && i == 0) ? 'h01 : (ph == 1 && i == 0) ? 'h11 : 'h21;
      end
   endfunction

   task automatic run_seq(int a0, int a1, int a2, int a3, bit s_a,
                          int b0, int b1, int b2, int b3, bit s_b,
                          int d, int s, int e, int tot, string scn);
      int hs_lines, rises;
      ca = '{a0, a1, a2, a3}; cb = '{b0, b1, b2, b3}; sa = s_a; sb = s_b;
      cur_d = d; cur_s = s; cur_e = e;
      for (int k = 0; k < MAXL; k++) begin
         ln_rise[k] = 0; ln_hi[k] = 0; ln_n[k] = 0; ln_vfirst[k] = -1;
         ln_vcyc[k] = 0; ln_endhs[k] = 0; ln_t[k][0] = '0; ln_t[k][1] = '0;
      end
      @(negedge clk);
      vsync_lines = CW'(a0); vbp_lines = CW'(a1); vact_lines = CW'(a2); vfp_lines = CW'(a3);
      strict_lp = s_a;
      base = cyc + 2;
      enable = 1'b1;
      mon_on = 1'b1;
      wait_cyc(base + L + 3);
      vsync_lines = CW'(b0); vbp_lines = CW'(b1); vact_lines = CW'(b2); vfp_lines = CW'(b3);
      strict_lp = s_b;
      wait_cyc(base + (tot - 1) * L + 2);
      enable = 1'b0;
      wait_cyc(base + (tot + 3) * L);
      mon_on = 1'b0;
      hs_lines = 0; rises = 0;
      for (int k = 0; k < tot + 3; k++) begin
         int n, t0, t1, hi;
         string tg, lb;
         exp_line(k, tot, n, t0, t1, tg);
         lb = $sformatf("%s %s line %0d", scn, tg, k);
         if (n > 0) hs_lines++;
         if (ln_n[k] > 0) rises++;
         chk(lb, ln_n[k], n, "packet count");
         if (n > 0) chk(lb, ln_t[k][0], t0, "first type");
         if (n > 1) chk(lb, ln_t[k][1], t1, "second type");
         if (n > 0) chk({lb, " R6"}, ln_vfirst[k], d, "rise-to-valid cycles");
         if (n > 0) chk({lb, " R7"}, ln_vcyc[k], s + n, "valid cycles");
         hi = (n > 0) ? d + s + n + e : 0;
         chk({lb, " R8"}, ln_hi[k], hi, "hs cycles");
         chk({lb, " R8"}, ln_endhs[k], 0, "hs at line end");
      end
      chk({scn, " R2"}, rises, hs_lines, "lines with bursts");
   endtask

   task automatic t_reset();
      int hs_seen;
      hs_seen = 0;
      @(negedge clk);
      chk("R1", hs_req, 0, "hs_req after reset");
      chk("R1", pkt_valid, 0, "pkt_valid after reset");
      for (int i = 0; i < 3 * L; i++) begin
         @(negedge clk);
         if (hs_req || pkt_valid) hs_seen++;
      end
      chk("R1", hs_seen, 0, "activity while disabled");
   endtask

   task automatic t_standard();
      run_seq(2, 2, 3, 2, 0, 2, 2, 3, 2, 0, 1, 0, 1, 18, "R2");
   endtask

   task automatic t_strict();
      run_seq(2, 3, 2, 2, 1, 2, 3, 2, 2, 1, 3, 1, 2, 18, "R5");
   endtask

   task automatic t_reload();
      run_seq(1, 1, 2, 1, 0, 1, 2, 4, 1, 0, 1, 0, 1, 13, "R9");
   endtask

   task automatic t_style_switch();
      run_seq(1, 1, 2, 1, 0, 1, 1, 2, 1, 1, 2, 0, 1, 10, "R9");
   endtask

   task automatic t_disable();
      run_seq(2, 2, 3, 2, 0, 2, 2, 3, 2, 0, 1, 0, 1, 4, "R10");
      run_seq(2, 2, 3, 2, 0, 2, 2, 3, 2, 0, 1, 0, 1, 2, "R10");
   endtask

   task automatic t_slow_phy();
      run_seq(1, 2, 2, 1, 0, 1, 2, 2, 1, 0, 4, 2, 3, 9, "R6");
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc == WD_CYCLES) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_standard();
      t_strict();
      t_reload();
      t_style_switch();
      t_disable();
      t_slow_phy();
      finish_run();
   end

endmodule